// File: doc/BRIEF.md
# Crosspoint Connection Register with Staged Update

This block is the digital control core of a small crosspoint switch. It holds two banks of connection codes, with one entry per switch output in each bank. The first bank holds pending codes. The second holds the codes that are live. A write names one output with a short output-select address and carries a wider input-select code on a shared bus. The code goes into the pending entry for that output, and the live switch state does not change. A separate update strobe copies the whole pending bank into the live bank in one cycle, so a full connection pattern changes at once. A clear strobe empties the live bank only. The staged pattern is kept, and a later update brings it back.

The three strobes (write, update, clear) come from outside the clock domain. Each one passes through a synchronizer, and it acts once, on the rising edge of its synchronized copy. Writes are accepted only while chip select is active and the bus is not in readback mode. In readback mode, with chip select active, the block drives the input-select bus with the live code of the addressed output and raises a separate drive-enable for the bus pads. The update strobe ignores chip select, so several of these blocks can switch together.

Top module: `xpt_conn_reg`

## Requirements
- R1: While the system reset `rstN` is low, both banks are cleared, every switch enable is 0, `inSelOe` is 0 and `inSelOut` is 0.
- R2: A rising edge on `wrStrobe`, with `chipSel`=1 and `readMode`=0, stores `inSelIn` into the pending entry of output `outSel`. The switch enables do not change.
- R3: A rising edge on `salvoStrobe` copies every pending entry into the live bank in the same cycle. The enables then follow the new live codes.
- R4: A live code drives the output's enables as follows. If bit 3 (the top bit) is 1, exactly one enable is set: bit `o*8 + code[2:0]` of `swEn`. If bit 3 is 0, all eight enables of output `o` are 0.
- R5: A rising edge on `clrStrobe` sets every live entry to 0 and leaves the pending bank unchanged. A later update restores the staged pattern.
- R6: If the clear and update edges are detected in the same cycle, the clear wins and the live bank becomes all 0.
- R7: A write edge while `chipSel`=0 changes no pending entry.
- R8: A write edge while `readMode`=1 changes no pending entry.
- R9: `inSelOe` is 1 exactly when `chipSel`=1 and `readMode`=1. While it is 1, `inSelOut` equals the live code of output `outSel`. Otherwise `inSelOut` is 0.
- R10: The update strobe takes effect whatever the value of `chipSel`.
- R11: Each strobe acts once per rising edge. Holding a strobe high does not repeat the action. An action is visible within three clock cycles after the strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| chipSel | input | 1 | Device select, active high |
| readMode | input | 1 | 1 turns the input-select bus into a readback output |
| wrStrobe | input | 1 | Write strobe, asynchronous |
| salvoStrobe | input | 1 | Global update strobe, asynchronous |
| clrStrobe | input | 1 | Live-bank clear strobe, asynchronous |
| outSel | input | 2 | Output-select address |
| inSelIn | input | 4 | Input-select code written to the pending bank |
| inSelOut | output | 4 | Readback of the live code for `outSel` |
| inSelOe | output | 1 | Drive enable for the input-select bus pads |
| swEn | output | 32 | One enable per output/input pair, bit `o*8+i` |

## Verification
The bench builds the block with its default parameters: a 2-bit output address, a 4-bit code and two synchronizer stages. This gives four outputs of eight inputs each. At this size the bench writes every one of the 16 codes to every output, then updates and reads back each one. That covers all 64 output/code pairs of the decode and the readback path. On top of the sweep, the bench runs directed cases. These cover writes that should be rejected, clear with restore, clear and update arriving together, and an update with chip select inactive. Every expected enable vector is worked out from a model of the two banks held in the bench.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  // One-cycle action pulses from control to datapath
  typedef struct packed {
    logic wr;
    logic salvo;
    logic clr;
  } xpt_strb_t;
endpackage

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrIn,
  input  logic               salvoIn,
  input  logic               clrIn,
  input  logic               chipSel,
  input  logic               readMode,
  output xpt_pkg::xpt_strb_t strb
);
  localparam int NUM_STROBES = 3;
  localparam int PIPE_LEN    = SYNC_STAGES + 1;

  logic [NUM_STROBES-1:0] rawIn;
  logic [NUM_STROBES-1:0] rise;

  assign rawIn = {clrIn, salvoIn, wrIn};

  for (genvar k = 0; k < NUM_STROBES; k++) begin : g_sync
    logic [PIPE_LEN-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[PIPE_LEN-2:0], rawIn[k]};
    end
    assign rise[k] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
  end

  always_comb begin
    strb.wr    = rise[0] & chipSel & ~readMode;
    strb.salvo = rise[1];
    strb.clr   = rise[2];
  end
endmodule

// File: rtl/xpt_datapath.sv
module xpt_datapath #(
  parameter int OUT_ADDR_W = 2,
  parameter int IN_ADDR_W  = 4
) (
  input  logic                                                 clk,
  input  logic                                                 rstN,
  input  xpt_pkg::xpt_strb_t                                   strb,
  input  logic                                                 chipSel,
  input  logic                                                 readMode,
  input  logic [OUT_ADDR_W-1:0]                                outSel,
  input  logic [IN_ADDR_W-1:0]                                 inSelIn,
  output logic [IN_ADDR_W-1:0]                                 inSelOut,
  output logic                                                 inSelOe,
  output logic [(1<<OUT_ADDR_W)*(1<<(IN_ADDR_W-1))-1:0]        swEn
);
  localparam int NUM_OUTS = 1 << OUT_ADDR_W;
  localparam int SEL_W    = IN_ADDR_W - 1;
  localparam int NUM_INS  = 1 << SEL_W;

  logic [NUM_OUTS-1:0][IN_ADDR_W-1:0] pending;
  logic [NUM_OUTS-1:0][IN_ADDR_W-1:0] active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pending <= '0;
    else if (strb.wr) pending[outSel] <= inSelIn;
  end

  // Clear outranks the update strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           active <= '0;
    else if (strb.clr)   active <= '0;
    else if (strb.salvo) active <= pending;
  end

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    for (genvar i = 0; i < NUM_INS; i++) begin : g_in
      assign swEn[o*NUM_INS+i] = active[o][IN_ADDR_W-1] &&
                                 (active[o][SEL_W-1:0] == SEL_W'(i));
    end
  end

  always_comb begin
    inSelOe  = chipSel & readMode;
    inSelOut = inSelOe ? active[outSel] : '0;
  end
endmodule

// File: rtl/xpt_conn_reg.sv
module xpt_conn_reg #(
  parameter int OUT_ADDR_W  = 2,
  parameter int IN_ADDR_W   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          chipSel,
  input  logic                                          readMode,
  input  logic                                          wrStrobe,
  input  logic                                          salvoStrobe,
  input  logic                                          clrStrobe,
  input  logic [OUT_ADDR_W-1:0]                         outSel,
  input  logic [IN_ADDR_W-1:0]                          inSelIn,
  output logic [IN_ADDR_W-1:0]                          inSelOut,
  output logic                                          inSelOe,
  output logic [(1<<OUT_ADDR_W)*(1<<(IN_ADDR_W-1))-1:0] swEn
);
  xpt_pkg::xpt_strb_t strb;

  xpt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrIn(wrStrobe), .salvoIn(salvoStrobe),
    .clrIn(clrStrobe), .chipSel(chipSel), .readMode(readMode), .strb(strb)
  );

  xpt_datapath #(.OUT_ADDR_W(OUT_ADDR_W), .IN_ADDR_W(IN_ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chipSel(chipSel),
    .readMode(readMode), .outSel(outSel), .inSelIn(inSelIn),
    .inSelOut(inSelOut), .inSelOe(inSelOe), .swEn(swEn)
  );
endmodule

// File: rtl/xpt_conn_reg_chk.sv
module xpt_conn_reg_chk #(
  parameter int OUT_ADDR_W = 2,
  parameter int IN_ADDR_W  = 4
) (
  input logic                                          clk,
  input logic                                          rstN,
  input xpt_pkg::xpt_strb_t                            strb,
  input logic                                          chipSel,
  input logic                                          readMode,
  input logic [IN_ADDR_W-1:0]                          inSelOut,
  input logic                                          inSelOe,
  input logic [(1<<OUT_ADDR_W)*(1<<(IN_ADDR_W-1))-1:0] swEn
);
  localparam int NUM_OUTS = 1 << OUT_ADDR_W;
  localparam int NUM_INS  = 1 << (IN_ADDR_W - 1);

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_seg
    assert_onehot_seg_R4: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(swEn[o*NUM_INS +: NUM_INS]));
  end

  assert_write_keeps_live_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && !strb.salvo && !strb.clr) |=> $stable(swEn));

  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (swEn == '0));

  assert_clear_beats_salvo_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr && strb.salvo) |=> (swEn == '0));

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    inSelOe |-> (chipSel && readMode));

  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inSelOe |-> (inSelOut == '0));

  assert_write_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |-> (chipSel && !readMode));
endmodule

bind xpt_conn_reg xpt_conn_reg_chk #(.OUT_ADDR_W(OUT_ADDR_W), .IN_ADDR_W(IN_ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .chipSel(chipSel), .readMode(readMode),
  .inSelOut(inSelOut), .inSelOe(inSelOe), .swEn(swEn)
);

// File: tb/tb_xpt_conn_reg.sv
module tb_xpt_conn_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 4;
  localparam int NI = 8;

  logic clk = 0;
  logic rstN = 0;
  logic chipSel = 0, readMode = 0, wrStrobe = 0, salvoStrobe = 0, clrStrobe = 0;
  logic [1:0] outSel = 0;
  logic [3:0] inSelIn = 0;
  logic [3:0] inSelOut;
  logic inSelOe;
  logic [NO*NI-1:0] swEn;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [3:0] pend [NO];
  logic [3:0] act [NO];

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_conn_reg dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .readMode(readMode),
    .wrStrobe(wrStrobe), .salvoStrobe(salvoStrobe), .clrStrobe(clrStrobe),
    .outSel(outSel), .inSelIn(inSelIn), .inSelOut(inSelOut),
    .inSelOe(inSelOe), .swEn(swEn)
  );

  function automatic logic [NO*NI-1:0] expSw();
    logic [NO*NI-1:0] v = '0;
    for (int o = 0; o < NO; o++)
      if (act[o][3]) v[o*NI + int'(act[o][2:0])] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input int o, input int c);
    @(negedge clk);
    outSel = 2'(o); inSelIn = 4'(c); wrStrobe = 1;
    idle(2); wrStrobe = 0; idle(3);
  endtask

  task automatic doSalvo();
    @(negedge clk); salvoStrobe = 1; idle(2); salvoStrobe = 0; idle(3);
  endtask

  task automatic doClear();
    @(negedge clk); clrStrobe = 1; idle(2); clrStrobe = 0; idle(3);
  endtask

  task automatic readBack(input string req);
    for (int o = 0; o < NO; o++) begin
      @(negedge clk); outSel = 2'(o); chipSel = 1; readMode = 1; #1;
      check(req, {28'd0, inSelOut}, {28'd0, act[o]});
      check(req, {31'd0, inSelOe}, 32'd1);
    end
    @(negedge clk); readMode = 0;
  endtask

  initial begin
    for (int o = 0; o < NO; o++) begin pend[o] = 0; act[o] = 0; end
    idle(3);
    #1;
    check("R1 enables", swEn, 32'd0);
    check("R1 oe", {31'd0, inSelOe}, 32'd0);
    check("R1 bus", {28'd0, inSelOut}, 32'd0);
    @(negedge clk); rstN = 1; chipSel = 1;

    // Sweep every output with every code
    for (int o = 0; o < NO; o++) begin
      for (int c = 0; c < 16; c++) begin
        doWrite(o, c); pend[o] = 4'(c);
        check("R2 write holds live", swEn, expSw());
        doSalvo(); for (int k = 0; k < NO; k++) act[k] = pend[k];
        check("R3/R4 salvo decode", swEn, expSw());
        @(negedge clk); outSel = 2'(o); readMode = 1; #1;
        check("R9 readback", {28'd0, inSelOut}, {28'd0, act[o]});
        @(negedge clk); readMode = 0;
      end
    end

    // Distinct pattern on all outputs
    doWrite(0, 4'hB); pend[0] = 4'hB;
    doWrite(1, 4'h8); pend[1] = 4'h8;
    doWrite(2, 4'h6); pend[2] = 4'h6;
    doWrite(3, 4'hF); pend[3] = 4'hF;
    doSalvo(); for (int k = 0; k < NO; k++) act[k] = pend[k];
    check("R3 pattern", swEn, expSw());
    readBack("R9 pattern readback");

    // R7: deselected write ignored
    chipSel = 0; doWrite(1, 4'hA); chipSel = 1;
    doSalvo();
    check("R7 deselected write", swEn, expSw());
    readBack("R7 readback");

    // R8: write in readback mode ignored
    readMode = 1; doWrite(2, 4'h9); readMode = 0;
    doSalvo();
    check("R8 readmode write", swEn, expSw());
    readBack("R8 readback");

    // R9: readMode with chipSel low -> bus idle
    @(negedge clk); chipSel = 0; readMode = 1; #1;
    check("R9 oe deselected", {31'd0, inSelOe}, 32'd0);
    check("R9 bus deselected", {28'd0, inSelOut}, 32'd0);
    @(negedge clk); readMode = 0; chipSel = 1;

    // R5: clear keeps pending, salvo restores
    doClear(); for (int k = 0; k < NO; k++) act[k] = 0;
    check("R5 clear", swEn, 32'd0);
    readBack("R5 cleared readback");
    doSalvo(); for (int k = 0; k < NO; k++) act[k] = pend[k];
    check("R5 restore", swEn, expSw());

    // R6: clear and salvo together
    doWrite(0, 4'hC); pend[0] = 4'hC;
    @(negedge clk); clrStrobe = 1; salvoStrobe = 1; idle(2);
    clrStrobe = 0; salvoStrobe = 0; idle(3);
    for (int k = 0; k < NO; k++) act[k] = 0;
    check("R6 clear wins", swEn, 32'd0);

    // R10: salvo with chipSel low
    chipSel = 0; doSalvo(); chipSel = 1;
    for (int k = 0; k < NO; k++) act[k] = pend[k];
    check("R10 ungated salvo", swEn, expSw());

    // R11: held strobe acts once; latency within three cycles
    doClear(); for (int k = 0; k < NO; k++) act[k] = 0;
    @(negedge clk); salvoStrobe = 1;
    idle(3); #1;
    for (int k = 0; k < NO; k++) act[k] = pend[k];
    check("R11 latency", swEn, expSw());
    @(negedge clk); clrStrobe = 1; idle(2); clrStrobe = 0; idle(3);
    for (int k = 0; k < NO; k++) act[k] = 0;
    idle(4);
    check("R11 held salvo no repeat", swEn, 32'd0);
    salvoStrobe = 0; idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule